// File: doc/BRIEF.md
# Flash Sector Erase-and-Program Sequencer

This block erases one sector of a byte-wide, memory-mapped flash device and then fills that sector from an incoming byte stream. It issues every command byte, data byte and status read on a simple single-cycle bus. The bus performs at most one access per clock. Between operations the block polls the device's status byte. It stops on the first failure it sees, and it reports success only after it has returned the device to read mode.

The host pulses `start_i` with a sector address and a byte count. It then supplies the sector contents in address order on a valid/ready stream. A byte transfers on a rising clock edge where `src_valid_i` and `src_ready_o` are both high. The source may hold `src_valid_i` low for any number of cycles, and the sequencer simply waits. `src_ready_o` is high only while the sequencer is waiting for the next byte. It stays low during every command write, data write and status poll, so the source is back-pressured for the whole duration of each flash operation. When the run ends on an error, the source still holds the bytes the sequencer never accepted, and the host discards them. Completion is shown on `done_o` or `err_o`, both held until the next start. When `err_o` is set, `err_status_o` gives the status byte that caused the failure.

Top module: `flash_sector_seq`

## Requirements
- R1: A run begins with the erase pair on the bus. The first access writes 0x30 to the base address. The next access writes 0xD0 to the sector address.
- R2: Each status read targets the base address. The read repeats on consecutive cycles until bit 7 of the returned byte is 1.
- R3: A polled status byte with bit 6 or bit 1 set is a failure, even when bit 7 is also set. The next access writes 0x50 to the base address, and `err_o` rises in the cycle after that write.
- R4: `err_status_o` holds the failing status byte. `done_o` and `err_o` are never high together. Each stays set until a start pulse clears both in the following cycle.
- R5: After a good erase and before the first data byte is fetched, the sequencer writes 0x50 to the base address once.
- R6: Each source byte that is programmed produces three things on the bus, in this order. First comes a write of 0x10 to the base address. Next comes a write of that byte to the sector address plus the byte's offset. Then comes a status poll.
- R7: A source byte of 0xFF is accepted from the stream but causes no bus access. The offset still advances, so the next byte lands at the following address.
- R8: After a good erase and program, the sequencer writes 0xFF to the base address, and `done_o` rises in the next cycle.
- R9: `src_ready_o` is high only while no bus access is in progress. A byte that is not accepted stays on the stream unchanged, however long valid is held low or high.
- R10: A sector size of 0 performs the erase, the pre-program clear and the final 0xFF write, and it fetches no bytes.
- R11: `fl_we_o` and `fl_re_o` are never high in the same cycle.
- R12: Out of reset, `done_o`, `err_o`, `src_ready_o`, `fl_we_o` and `fl_re_o` are low and `err_status_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled only while idle |
| sector_addr_i | input | ADDR_W | Sector start address on the flash bus, captured at start |
| sector_size_i | input | SIZE_W | Number of bytes to program, captured at start |
| src_valid_i | input | 1 | Stream byte valid |
| src_data_i | input | 8 | Stream byte |
| src_ready_o | output | 1 | Sequencer accepts a byte this cycle |
| done_o | output | 1 | Run finished without error (held) |
| err_o | output | 1 | Run aborted on a status failure (held) |
| err_status_o | output | 8 | Status byte that caused the abort |
| fl_addr_o | output | ADDR_W | Flash bus address |
| fl_wdata_o | output | 8 | Flash bus write data |
| fl_rdata_i | input | 8 | Flash bus read data, sampled at the edge ending a read cycle |
| fl_we_o | output | 1 | Flash write strobe |
| fl_re_o | output | 1 | Flash read strobe |

## Verification
The embedded properties check several things on every cycle. The strobes are exclusive. Stream readiness never overlaps a bus access. A failing poll is always followed by the clear-status write. Each confirm write follows an erase command, and each data write follows a program command. No 0xFF byte is ever written as data. Completion flags rise only after the matching closing write, and they persist until a start pulse. The exact order and addresses of whole runs can only be shown by the bench scenarios. Those scenarios cover skipped bytes shifting later addresses, gaps in the stream, failures in the erase phase and in the program phase, busy polls of varying length, and an empty sector. Each run is checked against an expected transaction list built from the requirements.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  localparam logic [7:0] CMD_SECT_ERASE = 8'h30;
  localparam logic [7:0] CMD_CONFIRM    = 8'hD0;
  localparam logic [7:0] CMD_PROGRAM    = 8'h10;
  localparam logic [7:0] CMD_CLR_STAT   = 8'h50;
  localparam logic [7:0] CMD_READ_MODE  = 8'hFF;
  localparam logic [7:0] SKIP_BYTE      = 8'hFF;

  localparam int STAT_RDY_BIT   = 7;
  localparam int STAT_EFAIL_BIT = 6;
  localparam int STAT_PFAIL_BIT = 1;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ER_CMD,
    S_ER_CONF,
    S_ER_POLL,
    S_PRE_CLR,
    S_FETCH,
    S_PG_CMD,
    S_PG_DATA,
    S_PG_POLL,
    S_FIN_RST,
    S_ERR_CLR
  } seq_state_e;

  typedef enum logic [1:0] {
    BUS_IDLE,
    BUS_WR,
    BUS_RD
  } bus_op_e;

  typedef enum logic [1:0] {
    ADR_BASE,
    ADR_SECTOR,
    ADR_TARGET
  } adr_sel_e;

endpackage

// File: rtl/flash_seq_status.sv
module flash_seq_status
  import flash_seq_pkg::*;
#(
  parameter int RDY_BIT   = STAT_RDY_BIT,
  parameter int EFAIL_BIT = STAT_EFAIL_BIT,
  parameter int PFAIL_BIT = STAT_PFAIL_BIT
) (
  input  logic [7:0] status_i,
  output logic       ready_o,
  output logic       fail_o
);

  always_comb begin
    ready_o = status_i[RDY_BIT];
    fail_o  = status_i[EFAIL_BIT] | status_i[PFAIL_BIT];
  end

endmodule

// File: rtl/flash_seq_offset.sv
module flash_seq_offset #(
  parameter int SIZE_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              inc_i,
  output logic [SIZE_W-1:0] offset_o,
  output logic              last_o,
  output logic              empty_o
);

  localparam logic [SIZE_W-1:0] ONE = SIZE_W'(1);

  logic [SIZE_W-1:0] size_q;
  logic [SIZE_W-1:0] off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= '0;
      off_q  <= '0;
    end else if (load_i) begin
      size_q <= size_i;
      off_q  <= '0;
    end else if (inc_i) begin
      off_q  <= off_q + ONE;
    end
  end

  always_comb begin
    offset_o = off_q;
    empty_o  = (size_q == '0);
    last_o   = !empty_o && (off_q == size_q - ONE);
  end

  AST_OFF_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_o) |-> (off_q < size_q)); // R7

endmodule

// File: rtl/flash_seq_busdrv.sv
module flash_seq_busdrv
  import flash_seq_pkg::*;
#(
  parameter int              ADDR_W    = 20,
  parameter int              SIZE_W    = 13,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  bus_op_e           op_i,
  input  adr_sel_e          sel_i,
  input  logic [7:0]        wbyte_i,
  input  logic [ADDR_W-1:0] sector_i,
  input  logic [SIZE_W-1:0] offset_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        wdata_o,
  output logic              we_o,
  output logic              re_o
);

  localparam int PAD_W = ADDR_W - SIZE_W;

  logic [ADDR_W-1:0] off_ext;

  generate
    if (PAD_W > 0) begin : g_pad
      assign off_ext = {{PAD_W{1'b0}}, offset_i};
    end else begin : g_trunc
      assign off_ext = offset_i[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (sel_i)
      ADR_SECTOR: addr_o = sector_i;
      ADR_TARGET: addr_o = sector_i + off_ext;
      default:    addr_o = BASE_ADDR;
    endcase
    we_o    = (op_i == BUS_WR);
    re_o    = (op_i == BUS_RD);
    wdata_o = we_o ? wbyte_i : 8'h00;
  end

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] sector_i,
  input  logic              s_valid_i,
  input  logic [7:0]        s_data_i,
  output logic              s_ready_o,
  input  logic              st_rdy_i,
  input  logic              st_fail_i,
  input  logic [7:0]        rdata_i,
  input  logic              off_last_i,
  input  logic              off_empty_i,
  output logic              off_load_o,
  output logic              off_inc_o,
  output bus_op_e           op_o,
  output adr_sel_e          sel_o,
  output logic [7:0]        wbyte_o,
  output logic [ADDR_W-1:0] sector_o,
  output logic              done_o,
  output logic              err_o,
  output logic [7:0]        err_status_o
);

  seq_state_e        state_q, state_d;
  logic [7:0]        byte_q;
  logic [ADDR_W-1:0] sector_q;
  logic              done_q, err_q;
  logic [7:0]        stat_q;
  logic              take_byte, set_done, set_err, latch_stat, clr_flags;

  always_comb begin
    state_d    = state_q;
    op_o       = BUS_IDLE;
    sel_o      = ADR_BASE;
    wbyte_o    = 8'h00;
    s_ready_o  = 1'b0;
    off_load_o = 1'b0;
    off_inc_o  = 1'b0;
    take_byte  = 1'b0;
    set_done   = 1'b0;
    set_err    = 1'b0;
    latch_stat = 1'b0;
    clr_flags  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start_i) begin
          clr_flags  = 1'b1;
          off_load_o = 1'b1;
          state_d    = S_ER_CMD;
        end
      end
      S_ER_CMD: begin
        op_o    = BUS_WR;
        wbyte_o = CMD_SECT_ERASE;
        state_d = S_ER_CONF;
      end
      S_ER_CONF: begin
        op_o    = BUS_WR;
        sel_o   = ADR_SECTOR;
        wbyte_o = CMD_CONFIRM;
        state_d = S_ER_POLL;
      end
      S_ER_POLL: begin
        op_o = BUS_RD;
        if (st_fail_i) begin
          latch_stat = 1'b1;
          state_d    = S_ERR_CLR;
        end else if (st_rdy_i) begin
          state_d = S_PRE_CLR;
        end
      end
      S_PRE_CLR: begin
        op_o    = BUS_WR;
        wbyte_o = CMD_CLR_STAT;
        state_d = off_empty_i ? S_FIN_RST : S_FETCH;
      end
      S_FETCH: begin
        s_ready_o = 1'b1;
        if (s_valid_i) begin
          if (s_data_i == SKIP_BYTE) begin
            if (off_last_i) state_d = S_FIN_RST;
            else            off_inc_o = 1'b1;
          end else begin
            take_byte = 1'b1;
            state_d   = S_PG_CMD;
          end
        end
      end
      S_PG_CMD: begin
        op_o    = BUS_WR;
        wbyte_o = CMD_PROGRAM;
        state_d = S_PG_DATA;
      end
      S_PG_DATA: begin
        op_o    = BUS_WR;
        sel_o   = ADR_TARGET;
        wbyte_o = byte_q;
        state_d = S_PG_POLL;
      end
      S_PG_POLL: begin
        op_o = BUS_RD;
        if (st_fail_i) begin
          latch_stat = 1'b1;
          state_d    = S_ERR_CLR;
        end else if (st_rdy_i) begin
          if (off_last_i) begin
            state_d = S_FIN_RST;
          end else begin
            off_inc_o = 1'b1;
            state_d   = S_FETCH;
          end
        end
      end
      S_FIN_RST: begin
        op_o     = BUS_WR;
        wbyte_o  = CMD_READ_MODE;
        set_done = 1'b1;
        state_d  = S_IDLE;
      end
      S_ERR_CLR: begin
        op_o    = BUS_WR;
        wbyte_o = CMD_CLR_STAT;
        set_err = 1'b1;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      byte_q   <= 8'h00;
      sector_q <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      stat_q   <= 8'h00;
    end else begin
      state_q <= state_d;
      if (take_byte)  byte_q <= s_data_i;
      if (clr_flags) begin
        sector_q <= sector_i;
        done_q   <= 1'b0;
        err_q    <= 1'b0;
      end
      if (latch_stat) stat_q <= rdata_i;
      if (set_done)   done_q <= 1'b1;
      if (set_err)    err_q  <= 1'b1;
    end
  end

  assign sector_o     = sector_q;
  assign done_o       = done_q;
  assign err_o        = err_q;
  assign err_status_o = stat_q;

  AST_CONFIRM_AFTER_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_o == BUS_WR && sel_o == ADR_SECTOR) |->
      ($past(op_o) == BUS_WR && $past(wbyte_o) == CMD_SECT_ERASE)); // R1
  AST_FAIL_THEN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (op_o == BUS_RD && st_fail_i) |=> (op_o == BUS_WR && wbyte_o == CMD_CLR_STAT)); // R3
  AST_READY_ONLY_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready_o |-> (op_o == BUS_IDLE)); // R9
  AST_DATA_AFTER_PROGRAM: assert property (@(posedge clk) disable iff (!rst_n)
    (op_o == BUS_WR && sel_o == ADR_TARGET) |->
      ($past(op_o) == BUS_WR && $past(wbyte_o) == CMD_PROGRAM)); // R6
  AST_NO_SKIP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_o == BUS_WR && sel_o == ADR_TARGET) |-> (wbyte_o != SKIP_BYTE)); // R7
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && err_q)); // R4
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !start_i) |=> done_q); // R4
  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !start_i) |=> (err_q && $stable(stat_q))); // R4

endmodule

// File: rtl/flash_sector_seq.sv
module flash_sector_seq
  import flash_seq_pkg::*;
#(
  parameter int                ADDR_W    = 20,
  parameter int                SIZE_W    = 13,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] sector_addr_i,
  input  logic [SIZE_W-1:0] sector_size_i,
  input  logic              src_valid_i,
  input  logic [7:0]        src_data_i,
  output logic              src_ready_o,
  output logic              done_o,
  output logic              err_o,
  output logic [7:0]        err_status_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [7:0]        fl_wdata_o,
  input  logic [7:0]        fl_rdata_i,
  output logic              fl_we_o,
  output logic              fl_re_o
);

  logic              st_rdy, st_fail;
  logic              off_load, off_inc, off_last, off_empty;
  logic [SIZE_W-1:0] offset;
  bus_op_e           op;
  adr_sel_e          sel;
  logic [7:0]        wbyte;
  logic [ADDR_W-1:0] sector;

  flash_seq_status i_status (
    .status_i (fl_rdata_i),
    .ready_o  (st_rdy),
    .fail_o   (st_fail)
  );

  flash_seq_offset #(.SIZE_W(SIZE_W)) i_offset (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (off_load),
    .size_i   (sector_size_i),
    .inc_i    (off_inc),
    .offset_o (offset),
    .last_o   (off_last),
    .empty_o  (off_empty)
  );

  flash_seq_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .sector_i     (sector_addr_i),
    .s_valid_i    (src_valid_i),
    .s_data_i     (src_data_i),
    .s_ready_o    (src_ready_o),
    .st_rdy_i     (st_rdy),
    .st_fail_i    (st_fail),
    .rdata_i      (fl_rdata_i),
    .off_last_i   (off_last),
    .off_empty_i  (off_empty),
    .off_load_o   (off_load),
    .off_inc_o    (off_inc),
    .op_o         (op),
    .sel_o        (sel),
    .wbyte_o      (wbyte),
    .sector_o     (sector),
    .done_o       (done_o),
    .err_o        (err_o),
    .err_status_o (err_status_o)
  );

  flash_seq_busdrv #(
    .ADDR_W    (ADDR_W),
    .SIZE_W    (SIZE_W),
    .BASE_ADDR (BASE_ADDR)
  ) i_busdrv (
    .op_i     (op),
    .sel_i    (sel),
    .wbyte_i  (wbyte),
    .sector_i (sector),
    .offset_i (offset),
    .addr_o   (fl_addr_o),
    .wdata_o  (fl_wdata_o),
    .we_o     (fl_we_o),
    .re_o     (fl_re_o)
  );

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we_o && fl_re_o)); // R11
  AST_POLL_AT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    fl_re_o |-> (fl_addr_o == BASE_ADDR)); // R2
  AST_DONE_AFTER_READ_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(fl_we_o && fl_wdata_o == CMD_READ_MODE && fl_addr_o == BASE_ADDR)); // R8
  AST_ERR_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> $past(fl_we_o && fl_wdata_o == CMD_CLR_STAT && fl_addr_o == BASE_ADDR)); // R3

endmodule

// File: tb/test_flash_sector_seq.sv
module test_flash_sector_seq;

  localparam int ADDR_W = 20;
  localparam int SIZE_W = 13;
  localparam logic [ADDR_W-1:0] BASE = '0;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] sect = '0;
  logic [SIZE_W-1:0] size = '0;
  logic              s_valid = 1'b0;
  logic [7:0]        s_data = 8'h00;
  logic              s_ready, done, err, fl_we, fl_re;
  logic [7:0]        err_st, fl_wdata;
  logic [ADDR_W-1:0] fl_addr;
  logic [7:0]        rd_cur = 8'h80;

  flash_sector_seq #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .BASE_ADDR(BASE)) i_flash_sector_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .sector_addr_i(sect), .sector_size_i(size),
    .src_valid_i(s_valid), .src_data_i(s_data), .src_ready_o(s_ready),
    .done_o(done), .err_o(err), .err_status_o(err_st),
    .fl_addr_o(fl_addr), .fl_wdata_o(fl_wdata), .fl_rdata_i(rd_cur),
    .fl_we_o(fl_we), .fl_re_o(fl_re)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  int                ek[$];
  logic [ADDR_W-1:0] ea[$];
  logic [7:0]        ed[$];
  logic [7:0]        stat_q[$];
  logic [7:0]        src_q[$];
  bit rd_pend = 0, hs_pend = 0, gap_mode = 0, flush_req = 0;
  int gcnt = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // per-cycle reference comparison
  always @(negedge clk) begin
    if (rd_pend) begin
      if (stat_q.size() > 0) void'(stat_q.pop_front());
      rd_pend = 0;
    end
    if (fl_we && fl_re) chk(0, "R11", "both strobes", 1, 0);
    if (fl_re && s_ready) chk(0, "R9", "ready during poll", 1, 0);
    if (fl_we || fl_re) begin
      if (ek.size() == 0) begin
        chk(0, cur_req, "unexpected bus access addr", int'(fl_addr), -1);
      end else begin
        int k; logic [ADDR_W-1:0] a; logic [7:0] d;
        k = ek.pop_front(); a = ea.pop_front(); d = ed.pop_front();
        chk(k == (fl_we ? 1 : 2), cur_req, "access kind", fl_we ? 1 : 2, k);
        chk(fl_addr == a, cur_req, "access addr", int'(fl_addr), int'(a));
        if (fl_we) chk(fl_wdata == d, cur_req, "write data", int'(fl_wdata), int'(d));
      end
    end
    if (fl_re) begin
      rd_cur  = (stat_q.size() > 0) ? stat_q[0] : 8'h80;
      rd_pend = 1;
    end
    // stream source with valid held until accepted
    gcnt++;
    if (hs_pend) begin
      if (src_q.size() > 0) void'(src_q.pop_front());
      s_valid = 0;
      hs_pend = 0;
    end
    if (flush_req) begin
      src_q.delete();
      s_valid = 0;
      flush_req = 0;
    end
    if (!s_valid && src_q.size() > 0 && !(gap_mode && (gcnt % 3 != 0))) begin
      s_valid = 1;
      s_data  = src_q[0];
    end
    hs_pend = s_valid && s_ready;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog expired: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic bit is_fail(input logic [7:0] s);
    return s[6] | s[1];
  endfunction

  task automatic exp_wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    ek.push_back(1); ea.push_back(a); ed.push_back(d);
  endtask

  task automatic exp_poll(input int busy, input logic [7:0] fin);
    for (int j = 0; j < busy; j++) begin
      ek.push_back(2); ea.push_back(BASE); ed.push_back(8'h00); stat_q.push_back(8'h00);
    end
    ek.push_back(2); ea.push_back(BASE); ed.push_back(8'h00); stat_q.push_back(fin);
  endtask

  task automatic run_case(input string req, input logic [ADDR_W-1:0] sa, input bit gap,
                          input logic [7:0] bytes[$], input int busy[$], input logic [7:0] fin[$]);
    bit e_err = 0;
    logic [7:0] e_st = 8'h00;
    int ph = 0;
    cur_req = req;
    // R1 erase pair, R2 poll
    exp_wr(BASE, 8'h30);
    exp_wr(sa, 8'hD0);
    exp_poll(busy[ph], fin[ph]);
    if (is_fail(fin[ph])) begin
      e_err = 1; e_st = fin[ph];
      exp_wr(BASE, 8'h50);            // R3
    end else begin
      exp_wr(BASE, 8'h50);            // R5
      for (int i = 0; i < bytes.size(); i++) begin
        if (bytes[i] != 8'hFF) begin  // R7 skip
          ph++;
          exp_wr(BASE, 8'h10);        // R6
          exp_wr(sa + ADDR_W'(i), bytes[i]);
          exp_poll(busy[ph], fin[ph]);
          if (is_fail(fin[ph])) begin
            e_err = 1; e_st = fin[ph];
            exp_wr(BASE, 8'h50);      // R3
            break;
          end
        end
      end
      if (!e_err) exp_wr(BASE, 8'hFF); // R8
    end
    @(negedge clk);
    gap_mode = gap;
    sect = sa;
    size = SIZE_W'(bytes.size());
    foreach (bytes[i]) src_q.push_back(bytes[i]);
    start = 1;
    @(negedge clk);
    start = 0;
    chk(!done && !err, "R4", "flags cleared by start", {done, err}, 0);
    begin
      int w = 0;
      while (!(done || err) && w < 5000) begin
        @(negedge clk);
        w++;
      end
    end
    chk(done == !e_err, req, "done flag", done, !e_err);
    chk(err == e_err, req, "err flag", err, e_err);
    if (e_err) chk(err_st == e_st, "R4", "error status", err_st, e_st);
    chk(ek.size() == 0, req, "remaining expected accesses", ek.size(), 0);
    repeat (6) @(negedge clk);
    chk(done == !e_err && err == e_err, "R4", "flags held", {done, err}, {!e_err, e_err});
    chk(!fl_we && !fl_re, "R4", "bus quiet after finish", {fl_we, fl_re}, 0);
    ek.delete(); ea.delete(); ed.delete(); stat_q.delete();
    flush_req = 1;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!done && !err && !s_ready, "R12", "reset flags/ready", {done, err, s_ready}, 0);
    chk(!fl_we && !fl_re && err_st == 8'h00, "R12", "reset bus/status", {fl_we, fl_re, err_st}, 0);

    // R6 R7: mixed bytes with skips, busy polls
    run_case("R7", 20'h00400, 0, '{8'h11, 8'hFF, 8'h22, 8'h33, 8'hFF, 8'h44},
             '{3, 1, 0, 2, 1}, '{8'h80, 8'h80, 8'h80, 8'h80, 8'h80});
    // R9: stream gaps, leading skip
    run_case("R9", 20'h00800, 1, '{8'hFF, 8'hA5, 8'h5A, 8'hFF, 8'h00},
             '{0, 0, 1, 0}, '{8'h80, 8'h80, 8'h80, 8'h80});
    // R3: erase failure via bit 6 without ready
    run_case("R3", 20'h01000, 0, '{8'h01, 8'h02},
             '{2}, '{8'h40});
    // R3: program failure via bit 1 with ready also set
    run_case("R3", 20'h01400, 1, '{8'h01, 8'h02, 8'h03, 8'h04},
             '{0, 0, 1}, '{8'h80, 8'h80, 8'h82});
    // R7 R8: all bytes skipped
    run_case("R8", 20'h02000, 0, '{8'hFF, 8'hFF, 8'hFF},
             '{1}, '{8'h80});
    // R10: empty sector
    run_case("R10", 20'h03000, 0, '{},
             '{0}, '{8'h80});
    // R2 R6: long busy and program at base-adjacent sector
    run_case("R2", 20'h00010, 0, '{8'hD0, 8'h30},
             '{5, 4, 3}, '{8'h80, 8'h80, 8'h80});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule